// File: doc/BRIEF.md
# Atomic Halfword Bit-Clear Unit

This block carries out one indivisible read-modify-write on a 16-bit memory halfword. It takes a decoded request made of three register indices (operand source, result destination, address base) and two ordering bits (acquire, release). It reads the operand and the base address through a register-file read port, or takes the stack pointer as the address when the base index is 31. It then issues a locked read to a simple memory port, clears in the loaded halfword every bit that is set in the operand, writes the result back and returns the value it loaded, zero-extended to 32 bits, to the destination register.

Alongside the data path the unit works out the ordering class of each memory phase. The read is ordered only if the acquire bit is set and the destination is a real register. The write is ordered exactly when the release bit is set. The unit also flags the store-only form of the request, in which nothing is returned. A request is refused with a fault code, and with no memory traffic and no writeback, when the atomic extension is switched off, when a stack-pointer base is not 16-byte aligned, or when the halfword address is odd.

Top module: `amo_hclr_unit`

## Requirements
- R1: The halfword written to memory equals the halfword read from the same address ANDed with the complement of the low 16 bits of the source register; a source index of 31 reads as zero, so the memory value is rewritten unchanged.
- R2: On success with a destination index other than 31, `wb_en` is high for exactly the cycle of `done`, with `wb_idx` equal to the destination index and `wb_data` equal to the loaded halfword in bits 15:0 and zero in bits 31:16; with destination index 31, `wb_en` never rises.
- R3: During the read phase `mem_ordered` is 1 exactly when the acquire bit is 1 and the destination index is not 31.
- R4: During the write phase `mem_ordered` is 1 exactly when the release bit is 1, whatever the destination index.
- R5: A base index of 31 takes `sp_value` as the address and any other index takes `rf_base_data`; a stack-pointer address whose bits 3:0 are not all zero ends the request with `done_fault` = 2, no memory request and no writeback.
- R6: An address with bit 0 set ends the request with `done_fault` = 3, no memory request and no writeback.
- R7: With `atomic_en` low the request ends with `done_fault` = 1 (undefined), no memory request and no writeback; this code takes priority over both alignment faults.
- R8: `done_alias` is 1 with `done` exactly when the acquire bit is 0 and the destination index is 31.
- R9: `mem_lock` is high from the first cycle of the read request until the cycle in which the write is acknowledged, without a gap; the read (`mem_we` = 0) precedes the write (`mem_we` = 1) and both use the same address.
- R10: `req_ready` is high only when the unit is idle; `done` is a single-cycle pulse per accepted request, with `done_fault` = 0 on success; after reset the unit is idle with no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| atomic_en | input | 1 | Atomic extension enabled |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Unit can accept a request |
| req_src_idx | input | 5 | Operand register index (31 reads as zero) |
| req_dst_idx | input | 5 | Destination register index (31 discards the result) |
| req_base_idx | input | 5 | Base register index (31 selects the stack pointer) |
| req_acq | input | 1 | Acquire bit |
| req_rel | input | 1 | Release bit |
| rf_src_idx | output | 5 | Register-file read index for the operand |
| rf_src_data | input | 64 | Register-file operand data |
| rf_base_idx | output | 5 | Register-file read index for the base |
| rf_base_data | input | 64 | Register-file base data |
| sp_value | input | 64 | Current stack pointer |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_lock | output | 1 | Locked pair in progress |
| mem_ordered | output | 1 | Current phase is ordered (acquire on read, release on write) |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | 16 | Write halfword |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 16 | Read halfword, valid with `mem_ack` on a read |
| wb_en | output | 1 | Destination register write enable |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | 32 | Zero-extended loaded halfword |
| done | output | 1 | Request complete (one cycle) |
| done_fault | output | 2 | 0 none, 1 undefined, 2 stack-pointer alignment, 3 odd address |
| done_alias | output | 1 | Store-only form indicator |

## Verification
A request is taken on the rising edge where `req_valid` and `req_ready` are both high; the read request appears in the next cycle, and with a memory that acknowledges one cycle after a request the write request follows two cycles after that, `done` with the writeback one cycle after the write acknowledge, five cycles after acceptance in all. A refused request shows `done` with its fault code in the cycle right after acceptance. The bench's driver queues the expected fault, return value, written halfword, ordering of each phase and handshake count, and a monitor sampling on the falling edge compares each memory phase as its acknowledge is seen and the rest as `done` appears, so no check depends on a fixed cycle count.

// File: rtl/amo_hclr_pkg.sv
package amo_hclr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_WRITE = 3'd2,
    ST_WB    = 3'd3,
    ST_FAULT = 3'd4
  } hclr_state_e;

  typedef enum logic [1:0] {
    FLT_NONE     = 2'd0,
    FLT_UNDEF    = 2'd1,
    FLT_SP_ALIGN = 2'd2,
    FLT_MISALIGN = 2'd3
  } hclr_fault_e;

  typedef struct packed {
    logic        ld_ord;
    logic        st_ord;
    logic        store_only;
    logic        wb_need;
    hclr_fault_e fault;
  } hclr_attr_t;

endpackage

// File: rtl/amo_hclr_rst_sync.sv
module amo_hclr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/amo_hclr_decode.sv
module amo_hclr_decode
  import amo_hclr_pkg::*;
#(
  parameter int IDX_W         = 5,
  parameter int ADDR_W        = 64,
  parameter int OP_W          = 16,
  parameter int SP_ALIGN_BITS = 4
) (
  input  logic              atomic_en,
  input  logic [IDX_W-1:0]  src_idx,
  input  logic [IDX_W-1:0]  dst_idx,
  input  logic [IDX_W-1:0]  base_idx,
  input  logic              acq,
  input  logic              rel,
  input  logic [ADDR_W-1:0] src_data,
  input  logic [ADDR_W-1:0] base_data,
  input  logic [ADDR_W-1:0] sp_data,
  output logic [OP_W-1:0]   operand,
  output logic [ADDR_W-1:0] addr,
  output hclr_attr_t        attr
);

  localparam logic [IDX_W-1:0] ZERO_IDX = '1;
  localparam int SIZE_BITS = $clog2(OP_W / 8);

  logic sel_sp;
  logic dst_is_zero;
  logic sp_misal;
  logic size_misal;

  assign sel_sp      = (base_idx == ZERO_IDX);
  assign dst_is_zero = (dst_idx == ZERO_IDX);
  assign addr        = sel_sp ? sp_data : base_data;
  assign operand     = (src_idx == ZERO_IDX) ? '0 : src_data[OP_W-1:0];
  assign sp_misal    = sel_sp && (|addr[SP_ALIGN_BITS-1:0]);

  generate
    if (SIZE_BITS == 0) begin : g_byte_size
      assign size_misal = 1'b0;
    end else begin : g_multi_byte
      assign size_misal = |addr[SIZE_BITS-1:0];
    end
  endgenerate

  always_comb begin
    attr.ld_ord     = acq && !dst_is_zero;
    attr.st_ord     = rel;
    attr.store_only = !acq && dst_is_zero;
    attr.wb_need    = !dst_is_zero;
    if (!atomic_en) begin
      attr.fault = FLT_UNDEF;
    end else if (sp_misal) begin
      attr.fault = FLT_SP_ALIGN;
    end else if (size_misal) begin
      attr.fault = FLT_MISALIGN;
    end else begin
      attr.fault = FLT_NONE;
    end
  end

endmodule

// File: rtl/amo_hclr_ctrl.sv
module amo_hclr_ctrl
  import amo_hclr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        fault_det,
  input  logic        mem_ack,
  output hclr_state_e state,
  output logic        req_ready,
  output logic        start,
  output logic        rd_capture,
  output logic        mem_req,
  output logic        mem_we,
  output logic        mem_lock,
  output logic        done,
  output logic        in_read,
  output logic        in_write,
  output logic        in_wb,
  output logic        in_fault
);

  hclr_state_e state_q;
  hclr_state_e state_d;

  assign req_ready = (state_q == ST_IDLE);
  assign start     = req_ready && req_valid;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = fault_det ? ST_FAULT : ST_READ;
        end
      end
      ST_READ: begin
        if (mem_ack) begin
          state_d = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (mem_ack) begin
          state_d = ST_WB;
        end
      end
      ST_WB:    state_d = ST_IDLE;
      ST_FAULT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign in_read    = (state_q == ST_READ);
  assign in_write   = (state_q == ST_WRITE);
  assign in_wb      = (state_q == ST_WB);
  assign in_fault   = (state_q == ST_FAULT);
  assign rd_capture = in_read && mem_ack;
  assign mem_req    = in_read || in_write;
  assign mem_we     = in_write;
  assign mem_lock   = in_read || in_write;
  assign done       = in_wb || in_fault;
  assign state      = state_q;

endmodule

// File: rtl/amo_hclr_datapath.sv
module amo_hclr_datapath
  import amo_hclr_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int ADDR_W = 64,
  parameter int OP_W   = 16,
  parameter int RET_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd_capture,
  input  logic [OP_W-1:0]   operand_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  hclr_attr_t        attr_in,
  input  logic [IDX_W-1:0]  dst_in,
  input  logic [OP_W-1:0]   rdata_in,
  output logic [ADDR_W-1:0] addr_q,
  output hclr_attr_t        attr_q,
  output logic [IDX_W-1:0]  dst_q,
  output logic [OP_W-1:0]   new_val,
  output logic [RET_W-1:0]  ret_val
);

  logic [OP_W-1:0] operand_q;
  logic [OP_W-1:0] old_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      operand_q <= '0;
      addr_q    <= '0;
      attr_q    <= '0;
      dst_q     <= '0;
    end else if (start) begin
      operand_q <= operand_in;
      addr_q    <= addr_in;
      attr_q    <= attr_in;
      dst_q     <= dst_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      old_q <= '0;
    end else if (rd_capture) begin
      old_q <= rdata_in;
    end
  end

  assign new_val = old_q & ~operand_q;
  assign ret_val = {{(RET_W-OP_W){1'b0}}, old_q};

endmodule

// File: rtl/amo_hclr_unit.sv
module amo_hclr_unit
  import amo_hclr_pkg::*;
#(
  parameter int IDX_W         = 5,
  parameter int ADDR_W        = 64,
  parameter int OP_W          = 16,
  parameter int RET_W         = 32,
  parameter int SP_ALIGN_BITS = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              atomic_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IDX_W-1:0]  req_src_idx,
  input  logic [IDX_W-1:0]  req_dst_idx,
  input  logic [IDX_W-1:0]  req_base_idx,
  input  logic              req_acq,
  input  logic              req_rel,
  output logic [IDX_W-1:0]  rf_src_idx,
  input  logic [ADDR_W-1:0] rf_src_data,
  output logic [IDX_W-1:0]  rf_base_idx,
  input  logic [ADDR_W-1:0] rf_base_data,
  input  logic [ADDR_W-1:0] sp_value,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_lock,
  output logic              mem_ordered,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [OP_W-1:0]   mem_wdata,
  input  logic              mem_ack,
  input  logic [OP_W-1:0]   mem_rdata,
  output logic              wb_en,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [RET_W-1:0]  wb_data,
  output logic              done,
  output logic [1:0]        done_fault,
  output logic              done_alias
);

  logic              rst_core_n;
  logic [OP_W-1:0]   dec_operand;
  logic [ADDR_W-1:0] dec_addr;
  hclr_attr_t        dec_attr;
  hclr_attr_t        attr_q;
  hclr_state_e       state;
  logic              start;
  logic              rd_capture;
  logic              in_read;
  logic              in_write;
  logic              in_wb;
  logic              in_fault;
  logic [IDX_W-1:0]  dst_q;
  logic [ADDR_W-1:0] addr_q;
  logic [OP_W-1:0]   new_val;
  logic [RET_W-1:0]  ret_val;

  amo_hclr_rst_sync #(
    .STAGES(SYNC_STAGES)
  ) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_core_n)
  );

  assign rf_src_idx  = req_src_idx;
  assign rf_base_idx = req_base_idx;

  amo_hclr_decode #(
    .IDX_W        (IDX_W),
    .ADDR_W       (ADDR_W),
    .OP_W         (OP_W),
    .SP_ALIGN_BITS(SP_ALIGN_BITS)
  ) u_decode (
    .atomic_en(atomic_en),
    .src_idx  (req_src_idx),
    .dst_idx  (req_dst_idx),
    .base_idx (req_base_idx),
    .acq      (req_acq),
    .rel      (req_rel),
    .src_data (rf_src_data),
    .base_data(rf_base_data),
    .sp_data  (sp_value),
    .operand  (dec_operand),
    .addr     (dec_addr),
    .attr     (dec_attr)
  );

  amo_hclr_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .req_valid (req_valid),
    .fault_det (dec_attr.fault != FLT_NONE),
    .mem_ack   (mem_ack),
    .state     (state),
    .req_ready (req_ready),
    .start     (start),
    .rd_capture(rd_capture),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_lock  (mem_lock),
    .done      (done),
    .in_read   (in_read),
    .in_write  (in_write),
    .in_wb     (in_wb),
    .in_fault  (in_fault)
  );

  amo_hclr_datapath #(
    .IDX_W (IDX_W),
    .ADDR_W(ADDR_W),
    .OP_W  (OP_W),
    .RET_W (RET_W)
  ) u_datapath (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .start     (start),
    .rd_capture(rd_capture),
    .operand_in(dec_operand),
    .addr_in   (dec_addr),
    .attr_in   (dec_attr),
    .dst_in    (req_dst_idx),
    .rdata_in  (mem_rdata),
    .addr_q    (addr_q),
    .attr_q    (attr_q),
    .dst_q     (dst_q),
    .new_val   (new_val),
    .ret_val   (ret_val)
  );

  assign mem_addr    = addr_q;
  assign mem_wdata   = new_val;
  assign mem_ordered = (in_read && attr_q.ld_ord) || (in_write && attr_q.st_ord);
  assign wb_en       = in_wb && attr_q.wb_need;
  assign wb_idx      = dst_q;
  assign wb_data     = ret_val;
  assign done_fault  = in_fault ? attr_q.fault : FLT_NONE;
  assign done_alias  = done && attr_q.store_only;

endmodule

// File: rtl/amo_hclr_checker.sv
module amo_hclr_checker #(
  parameter int IDX_W  = 5,
  parameter int ADDR_W = 64,
  parameter int OP_W   = 16,
  parameter int RET_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic              mem_lock,
  input logic              mem_ordered,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              done,
  input logic [1:0]        done_fault,
  input logic              wb_en,
  input logic [IDX_W-1:0]  wb_idx,
  input logic [RET_W-1:0]  wb_data
);

  a_r9_lock_covers_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_lock);

  a_r9_lock_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_lock && !(mem_we && mem_ack)) |=> mem_lock);

  a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_lock && !(mem_we && mem_ack)) |=> $stable(mem_addr));

  a_r9_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we));

  a_r2_no_zero_reg_wb: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_idx != {IDX_W{1'b1}}));

  a_r2_zero_extended: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_data[RET_W-1:OP_W] == '0));

  a_r2_wb_with_success: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (done && done_fault == 2'd0));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_lock && !done));

  a_r3_ordered_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ordered |-> mem_req);

  a_r7_fault_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_fault != 2'd0) |-> (!mem_req && !wb_en));

endmodule

bind amo_hclr_unit amo_hclr_checker #(
  .IDX_W (IDX_W),
  .ADDR_W(ADDR_W),
  .OP_W  (OP_W),
  .RET_W (RET_W)
) u_amo_hclr_checker (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .req_ready  (req_ready),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_ack    (mem_ack),
  .mem_lock   (mem_lock),
  .mem_ordered(mem_ordered),
  .mem_addr   (mem_addr),
  .done       (done),
  .done_fault (done_fault),
  .wb_en      (wb_en),
  .wb_idx     (wb_idx),
  .wb_data    (wb_data)
);

// File: tb/test_amo_hclr_unit.sv
`timescale 1ns/1ps
module test_amo_hclr_unit;

  logic        clk;
  logic        rst_n;
  logic        atomic_en;
  logic        req_valid;
  logic        req_ready;
  logic [4:0]  req_src_idx;
  logic [4:0]  req_dst_idx;
  logic [4:0]  req_base_idx;
  logic        req_acq;
  logic        req_rel;
  logic [4:0]  rf_src_idx;
  logic [63:0] rf_src_data;
  logic [4:0]  rf_base_idx;
  logic [63:0] rf_base_data;
  logic [63:0] sp_value;
  logic        mem_req;
  logic        mem_we;
  logic        mem_lock;
  logic        mem_ordered;
  logic [63:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_ack;
  logic [15:0] mem_rdata;
  logic        wb_en;
  logic [4:0]  wb_idx;
  logic [31:0] wb_data;
  logic        done;
  logic [1:0]  done_fault;
  logic        done_alias;

  int checks;
  int errors;

  logic [63:0] rf [32];
  logic [15:0] mem [32];
  logic [15:0] shadow [32];

  typedef struct {
    string       tag;
    logic [1:0]  fault;
    logic        wb_en;
    logic [4:0]  wb_idx;
    logic [31:0] wb_data;
    logic        alias_f;
    int          hs;
    logic        ld_ord;
    logic        st_ord;
    logic [63:0] addr;
    logic [15:0] wdata;
  } exp_t;

  exp_t exp_q[$];
  int   hs_cnt;

  amo_hclr_unit i_amo_hclr_unit (
    .clk(clk), .rst_n(rst_n), .atomic_en(atomic_en),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_src_idx(req_src_idx), .req_dst_idx(req_dst_idx), .req_base_idx(req_base_idx),
    .req_acq(req_acq), .req_rel(req_rel),
    .rf_src_idx(rf_src_idx), .rf_src_data(rf_src_data),
    .rf_base_idx(rf_base_idx), .rf_base_data(rf_base_data), .sp_value(sp_value),
    .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock), .mem_ordered(mem_ordered),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
    .done(done), .done_fault(done_fault), .done_alias(done_alias)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  assign rf_src_data  = rf[rf_src_idx];
  assign rf_base_data = rf[rf_base_idx];

  // memory model: acknowledges one cycle after each request
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= 16'h0;
      for (int i = 0; i < 32; i++) mem[i] <= 16'(i * 16'h1111) ^ 16'h5A5A;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        if (mem_we) mem[mem_addr[5:1]] <= mem_wdata;
        else        mem_rdata <= mem[mem_addr[5:1]];
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      if (mem_req && mem_ack) begin
        hs_cnt++;
        chk("R9", "lock during phase", 64'(mem_lock), 64'd1);
        chk("R5", "memory address", mem_addr, exp_q[0].addr);
        if (!mem_we) begin
          chk("R3", {exp_q[0].tag, " read ordering"}, 64'(mem_ordered), 64'(exp_q[0].ld_ord));
        end else begin
          chk("R4", {exp_q[0].tag, " write ordering"}, 64'(mem_ordered), 64'(exp_q[0].st_ord));
          chk("R1", {exp_q[0].tag, " written halfword"}, 64'(mem_wdata), 64'(exp_q[0].wdata));
          chk("R9", "second handshake is the write", 64'(hs_cnt), 64'd2);
        end
      end
      if (wb_en && !done) chk("R2", "writeback outside done", 64'd1, 64'd0);
      if (done) begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R10", {e.tag, " fault code"}, 64'(done_fault), 64'(e.fault));
        chk("R2", {e.tag, " writeback enable"}, 64'(wb_en), 64'(e.wb_en));
        if (e.wb_en) begin
          chk("R2", {e.tag, " writeback index"}, 64'(wb_idx), 64'(e.wb_idx));
          chk("R2", {e.tag, " writeback data"}, 64'(wb_data), 64'(e.wb_data));
        end
        chk("R8", {e.tag, " alias flag"}, 64'(done_alias), 64'(e.alias_f));
        chk("R7", {e.tag, " memory handshakes"}, 64'(hs_cnt), 64'(e.hs));
        hs_cnt = 0;
      end
    end
  end

  task automatic run_op(input string tag, input logic en,
                        input logic [4:0] src, input logic [4:0] dst, input logic [4:0] base,
                        input logic acq, input logic rel,
                        input logic [63:0] srcval, input logic [63:0] baseval,
                        input logic [63:0] spval);
    exp_t        e;
    logic [63:0] a;
    logic [15:0] op;
    logic [15:0] old;
    a  = (base == 5'd31) ? spval : baseval;
    op = (src == 5'd31) ? 16'h0 : srcval[15:0];
    e.tag = tag;
    if (!en)                                  e.fault = 2'd1;
    else if (base == 5'd31 && a[3:0] != 4'h0) e.fault = 2'd2;
    else if (a[0])                            e.fault = 2'd3;
    else                                      e.fault = 2'd0;
    old       = shadow[a[5:1]];
    e.addr    = a;
    e.wdata   = old & ~op;
    e.wb_en   = (e.fault == 2'd0) && (dst != 5'd31);
    e.wb_idx  = dst;
    e.wb_data = {16'h0, old};
    e.alias_f = !acq && (dst == 5'd31);
    e.hs      = (e.fault == 2'd0) ? 2 : 0;
    e.ld_ord  = acq && (dst != 5'd31);
    e.st_ord  = rel;
    if (e.fault == 2'd0) shadow[a[5:1]] = e.wdata;
    @(negedge clk);
    if (src != 5'd31) rf[src] = srcval;
    if (base != 5'd31) rf[base] = baseval;
    sp_value     = spval;
    atomic_en    = en;
    req_src_idx  = src;
    req_dst_idx  = dst;
    req_base_idx = base;
    req_acq      = acq;
    req_rel      = rel;
    chk("R10", {tag, " ready when idle"}, 64'(req_ready), 64'd1);
    exp_q.push_back(e);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  localparam logic [63:0] HI = 64'h1234_5678_0000_0000;

  initial begin
    checks = 0; errors = 0; hs_cnt = 0;
    rst_n = 1'b0; atomic_en = 1'b1; req_valid = 1'b0;
    req_src_idx = '0; req_dst_idx = '0; req_base_idx = '0;
    req_acq = 1'b0; req_rel = 1'b0; sp_value = '0;
    for (int i = 0; i < 32; i++) begin
      rf[i] = 64'hFFFF_FFFF_FFFF_FFFF;
      shadow[i] = 16'(i * 16'h1111) ^ 16'h5A5A;
    end
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10", "reset ready", 64'(req_ready), 64'd1);
    chk("R10", "reset no request", 64'(mem_req), 64'd0);
    chk("R10", "reset no done", 64'(done), 64'd0);
    chk("R9", "reset no lock", 64'(mem_lock), 64'd0);

    // R1 R2 basic clear, plain ordering
    run_op("R1 basic", 1'b1, 5'd3, 5'd5, 5'd7, 1'b0, 1'b0, 64'hDEAD_00F0, HI | 64'h4, 64'h0);
    // R3 R4 acquire and release with real destination
    run_op("R3 acq-rel", 1'b1, 5'd2, 5'd9, 5'd8, 1'b1, 1'b1, 64'h0000_FF0F, HI | 64'h10, 64'h0);
    // R3 acquire dropped with zero destination, no writeback
    run_op("R3 acq zero dst", 1'b1, 5'd4, 5'd31, 5'd6, 1'b1, 1'b0, 64'h0000_0101, HI | 64'h20, 64'h0);
    // R8 R4 store-only form with release
    run_op("R8 store-only", 1'b1, 5'd4, 5'd31, 5'd6, 1'b0, 1'b1, 64'h0000_8000, HI | 64'h22, 64'h0);
    // R1 zero-register source leaves memory unchanged
    run_op("R1 zero src", 1'b1, 5'd31, 5'd10, 5'd7, 1'b0, 1'b0, 64'h0, HI | 64'h4, 64'h0);
    // R1 same address again accumulates
    run_op("R1 repeat", 1'b1, 5'd3, 5'd11, 5'd7, 1'b0, 1'b1, 64'h0000_0F00, HI | 64'h4, 64'h0);
    // R5 stack pointer base, aligned
    run_op("R5 sp base", 1'b1, 5'd3, 5'd12, 5'd31, 1'b1, 1'b0, 64'h0000_00FF, 64'h0, HI | 64'h30);
    // R5 stack pointer misaligned by 8
    run_op("R5 sp misaligned", 1'b1, 5'd3, 5'd12, 5'd31, 1'b0, 1'b0, 64'h0000_FFFF, 64'h0, HI | 64'h38);
    // R6 odd address from a general register
    run_op("R6 odd address", 1'b1, 5'd3, 5'd13, 5'd7, 1'b0, 1'b0, 64'h0000_FFFF, HI | 64'h5, 64'h0);
    // R7 extension disabled
    run_op("R7 undefined", 1'b0, 5'd3, 5'd14, 5'd7, 1'b1, 1'b1, 64'h0000_FFFF, HI | 64'h8, 64'h0);
    // R7 undefined takes priority over a misaligned stack pointer
    run_op("R7 priority", 1'b0, 5'd3, 5'd14, 5'd31, 1'b0, 1'b0, 64'h0000_FFFF, 64'h0, HI | 64'h1);
    // R2 back in service after faults
    run_op("R2 after faults", 1'b1, 5'd1, 5'd15, 5'd7, 1'b1, 1'b0, 64'h0000_0003, HI | 64'h8, 64'h0);

    repeat (2) @(negedge clk);
    chk("R9", "lock released at end", 64'(mem_lock), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule